// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block is an external sequencer that takes a processor with three power domains (core logic, a vector/media engine, and the cache RAM arrays) into and out of its deep low-power states. Software raises a dormant or a shutdown request. The sequencer then waits until the core reports that it has saved its state and is idle in wait-for-interrupt. After that it isolates the domains with clamps, holds the core in reset and switches the power off. In dormant mode the RAM domain is kept in retention. A wake-up event starts the return path. The sequencer powers the domains up and waits for each one to acknowledge power-good. It then counts a programmable settle time and releases the clamps. Core reset is released last.

A debug keep-on input selects an emulation mode. In this mode the clamp and reset handshake runs as usual, but every domain stays powered. In normal running the vector engine domain can also be switched off and back on by itself behind its own clamp, without touching the core or the RAMs.

States: `ST_RUN`, `ST_WAIT_STBY`, `ST_CLAMP`, `ST_RESET`, `ST_OFF`, `ST_PWR_ON`, `ST_SETTLE`, `ST_UNCLAMP`, `ST_VEC_CLAMP`, `ST_VEC_DOWN`, `ST_VEC_UP`, `ST_VEC_SETTLE`.

Transitions:
- RUN → WAIT_STBY on either request.
- RUN → VEC_CLAMP on a vector-off request.
- WAIT_STBY → CLAMP when standby-ready is seen.
- CLAMP → RESET → OFF unconditionally.
- OFF → PWR_ON on wake.
- PWR_ON → SETTLE when all three acknowledges are high.
- SETTLE → UNCLAMP when the counter reaches zero.
- UNCLAMP → RUN.
- VEC_CLAMP → VEC_DOWN.
- VEC_DOWN → VEC_UP when the vector-off request drops.
- VEC_UP → VEC_SETTLE on the vector acknowledge.
- VEC_SETTLE → RUN when the counter reaches zero.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, the outputs show the run state. That means both clamps low, core_rst low, all three power enables high and ram_retain low. An asynchronous reset in the middle of a sequence returns the block to this state.
- R2: In the run state, a high req_dormant or req_shutdown moves the block to a waiting state in which no output changes. Both clamps rise one cycle after the edge on which core_stby_ready is sampled high in that state.
- R3: A domain's clamp is high at least one cycle before that domain's power enable falls.
- R4: core_rst rises one cycle after the clamps. It is high at least one cycle before the logic or RAM power enable falls.
- R5: One cycle after reset is asserted, the low-power state is entered. For dormant, the logic, vector and RAM enables are low and ram_retain is high. For shutdown, all enables are low and ram_retain is low. When both requests are high together, shutdown wins. The mode is captured when the request is accepted.
- R6: The low-power state lasts until wake_evt is sampled high. The next cycle has all enables high and ram_retain low, with clamps and core_rst still high.
- R7: After power-on the block waits until pg_logic_ack, pg_vec_ack and pg_ram_ack are all high. It then stays settle_cycles+1 cycles in settle. Next it drops both clamps with core_rst still high for one cycle. Only then is core_rst released, as the last step.
- R8: If dbg_keep_on is high on the cycle core_stby_ready is accepted, the whole clamp and reset sequence runs, but all enables stay high and ram_retain stays low. A later change of dbg_keep_on has no effect on that sequence.
- R9: In the run state, a high vec_off_req raises clamp_vec. One cycle later pwr_vec_en drops. Logic and RAM power and core_rst are unaffected. On release, pwr_vec_en returns, the block waits for pg_vec_ack, settles, and then drops clamp_vec.
- R10: Dormant and shutdown requests are ignored outside the run state, for example while the vector domain is off.
- R11: With settle_cycles = 0 the settle step lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_dormant | input | 1 | Software request for dormant mode |
| req_shutdown | input | 1 | Software request for shutdown mode |
| core_stby_ready | input | 1 | Core has saved state and idles in wait-for-interrupt |
| wake_evt | input | 1 | External wake-up event |
| dbg_keep_on | input | 1 | Debug request to emulate power-down |
| vec_off_req | input | 1 | Run-mode request to switch off the vector domain |
| settle_cycles | input | CNT_W | Settle delay after power-good |
| pg_logic_ack | input | 1 | Power-good from the logic domain |
| pg_vec_ack | input | 1 | Power-good from the vector domain |
| pg_ram_ack | input | 1 | Power-good from the RAM domain |
| clamp_vec | output | 1 | Isolation clamp for the vector domain |
| clamp_ram | output | 1 | Isolation clamp for the RAM domain |
| core_rst | output | 1 | Active-high core reset |
| pwr_logic_en | output | 1 | Logic domain power switch enable |
| pwr_vec_en | output | 1 | Vector domain power switch enable |
| pwr_ram_en | output | 1 | RAM domain full power enable |
| ram_retain | output | 1 | RAM domain retention enable |

## Verification
Every output is decoded from the state register alone, so each result is due one clock after the edge that samples the input causing it. The settle step is the exception: it adds settle_cycles+1 edges after the power-good edge. The bench drives inputs on the falling edge and compares all seven outputs shortly after each rising edge. The vector table therefore lists one expected output set per clock, placed on the cycle in which the state register changes. The directed tests count edges in the same way for the zero-settle case and for a reset in the middle of a sequence.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        ST_RUN        = 4'd0,
        ST_WAIT_STBY  = 4'd1,
        ST_CLAMP      = 4'd2,
        ST_RESET      = 4'd3,
        ST_OFF        = 4'd4,
        ST_PWR_ON     = 4'd5,
        ST_SETTLE     = 4'd6,
        ST_UNCLAMP    = 4'd7,
        ST_VEC_CLAMP  = 4'd8,
        ST_VEC_DOWN   = 4'd9,
        ST_VEC_UP     = 4'd10,
        ST_VEC_SETTLE = 4'd11
    } seq_state_t;

    typedef struct packed {
        logic clamp_vec;
        logic clamp_ram;
        logic core_rst;
        logic logic_en;
        logic vec_en;
        logic ram_en;
        logic ram_ret;
    } pwr_ctl_t;

endpackage

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_dormant,
    input  logic     req_shutdown,
    input  logic     core_stby_ready,
    input  logic     wake_evt,
    input  logic     dbg_keep_on,
    input  logic     vec_off_req,
    input  logic     pg_logic_ack,
    input  logic     pg_vec_ack,
    input  logic     pg_ram_ack,
    input  logic     tmr_expired,
    output logic     tmr_load,
    output pwr_ctl_t ctl
);
    seq_state_t state_q, state_d;
    logic       shut_q;   // captured mode: 1 = shutdown, 0 = dormant
    logic       emu_q;    // captured debug keep-on
    logic       all_pg;

    assign all_pg = pg_logic_ack & pg_vec_ack & pg_ram_ack;

    // state register and mode capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            shut_q  <= 1'b0;
            emu_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && state_d == ST_WAIT_STBY) begin
                shut_q <= req_shutdown;
            end
            if (state_q == ST_WAIT_STBY && state_d == ST_CLAMP) begin
                emu_q <= dbg_keep_on;
            end
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (req_dormant || req_shutdown) begin
                    state_d = ST_WAIT_STBY;
                end else if (vec_off_req) begin
                    state_d = ST_VEC_CLAMP;
                end
            end
            ST_WAIT_STBY: if (core_stby_ready) state_d = ST_CLAMP;
            ST_CLAMP:     state_d = ST_RESET;
            ST_RESET:     state_d = ST_OFF;
            ST_OFF:       if (wake_evt) state_d = ST_PWR_ON;
            ST_PWR_ON: begin
                if (all_pg) begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                end
            end
            ST_SETTLE:    if (tmr_expired) state_d = ST_UNCLAMP;
            ST_UNCLAMP:   state_d = ST_RUN;
            ST_VEC_CLAMP: state_d = ST_VEC_DOWN;
            ST_VEC_DOWN:  if (!vec_off_req) state_d = ST_VEC_UP;
            ST_VEC_UP: begin
                if (pg_vec_ack) begin
                    state_d  = ST_VEC_SETTLE;
                    tmr_load = 1'b1;
                end
            end
            ST_VEC_SETTLE: if (tmr_expired) state_d = ST_RUN;
            default:       state_d = ST_RUN;
        endcase
    end

    // output decode from state and captured mode
    always_comb begin
        ctl = '{clamp_vec: 1'b0, clamp_ram: 1'b0, core_rst: 1'b0,
                logic_en: 1'b1, vec_en: 1'b1, ram_en: 1'b1, ram_ret: 1'b0};
        unique case (state_q)
            ST_RUN, ST_WAIT_STBY: ;
            ST_CLAMP: begin
                ctl.clamp_vec = 1'b1;
                ctl.clamp_ram = 1'b1;
            end
            ST_RESET, ST_PWR_ON, ST_SETTLE: begin
                ctl.clamp_vec = 1'b1;
                ctl.clamp_ram = 1'b1;
                ctl.core_rst  = 1'b1;
            end
            ST_OFF: begin
                ctl.clamp_vec = 1'b1;
                ctl.clamp_ram = 1'b1;
                ctl.core_rst  = 1'b1;
                ctl.logic_en  = emu_q;
                ctl.vec_en    = emu_q;
                ctl.ram_en    = emu_q;
                ctl.ram_ret   = !emu_q && !shut_q;
            end
            ST_UNCLAMP: ctl.core_rst = 1'b1;
            ST_VEC_CLAMP, ST_VEC_UP, ST_VEC_SETTLE: ctl.clamp_vec = 1'b1;
            ST_VEC_DOWN: begin
                ctl.clamp_vec = 1'b1;
                ctl.vec_en    = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_dormant,
    input  logic             req_shutdown,
    input  logic             core_stby_ready,
    input  logic             wake_evt,
    input  logic             dbg_keep_on,
    input  logic             vec_off_req,
    input  logic [CNT_W-1:0] settle_cycles,
    input  logic             pg_logic_ack,
    input  logic             pg_vec_ack,
    input  logic             pg_ram_ack,
    output logic             clamp_vec,
    output logic             clamp_ram,
    output logic             core_rst,
    output logic             pwr_logic_en,
    output logic             pwr_vec_en,
    output logic             pwr_ram_en,
    output logic             ram_retain
);
    pwr_ctl_t ctl;
    logic     tmr_load;
    logic     tmr_expired;

    pwr_seq_fsm fsm_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_dormant     (req_dormant),
        .req_shutdown    (req_shutdown),
        .core_stby_ready (core_stby_ready),
        .wake_evt        (wake_evt),
        .dbg_keep_on     (dbg_keep_on),
        .vec_off_req     (vec_off_req),
        .pg_logic_ack    (pg_logic_ack),
        .pg_vec_ack      (pg_vec_ack),
        .pg_ram_ack      (pg_ram_ack),
        .tmr_expired     (tmr_expired),
        .tmr_load        (tmr_load),
        .ctl             (ctl)
    );

    pwr_settle_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (settle_cycles),
        .expired  (tmr_expired)
    );

    assign clamp_vec    = ctl.clamp_vec;
    assign clamp_ram    = ctl.clamp_ram;
    assign core_rst     = ctl.core_rst;
    assign pwr_logic_en = ctl.logic_en;
    assign pwr_vec_en   = ctl.vec_en;
    assign pwr_ram_en   = ctl.ram_en;
    assign ram_retain   = ctl.ram_ret;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wake_evt,
    input logic pg_logic_ack,
    input logic pg_vec_ack,
    input logic pg_ram_ack,
    input logic clamp_vec,
    input logic clamp_ram,
    input logic core_rst,
    input logic pwr_logic_en,
    input logic pwr_vec_en,
    input logic pwr_ram_en,
    input logic ram_retain
);
    AST_CLAMP_VEC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_vec_en) |-> $past(clamp_vec)); // R3
    AST_CLAMP_RAM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_ram_en) |-> $past(clamp_ram)); // R3
    AST_RST_BEFORE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_logic_en) |-> $past(core_rst)); // R4
    AST_RST_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> (pwr_logic_en && pwr_vec_en && pwr_ram_en && !clamp_vec && !clamp_ram)); // R7
    AST_UNCLAMP_AFTER_PG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clamp_ram) |-> (pg_logic_ack && pg_vec_ack && pg_ram_ack)); // R7
    AST_RETAIN_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ram_retain |-> (!pwr_ram_en && !pwr_logic_en && !pwr_vec_en)); // R5
    AST_WAKE_BEFORE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_logic_en) |-> $past(wake_evt)); // R6
    AST_VEC_ALONE_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwr_vec_en) && pwr_logic_en) |-> !core_rst); // R9
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk chk_i (.*);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;
    localparam int CNT_W = 8;
    localparam int NVEC  = 43;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_dormant = 0, req_shutdown = 0, core_stby_ready = 0, wake_evt = 0;
    logic dbg_keep_on = 0, vec_off_req = 0;
    logic pg_logic_ack = 1, pg_vec_ack = 1, pg_ram_ack = 1;
    logic [CNT_W-1:0] settle_cycles = 8'd2;
    logic clamp_vec, clamp_ram, core_rst, pwr_logic_en, pwr_vec_en, pwr_ram_en, ram_retain;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwr_seq_ctrl #(.CNT_W(CNT_W)) dut_i (.*);

    // inputs {rd, rs, stby, wake, dbg, voff, pgl, pgv, pgr} / expected {cv, cr, rst, le, ve, re, ret}
    localparam logic [15:0] VEC [NVEC] = '{
        16'b100000_111_0001110, // 0  R2 request
        16'b000000_111_0001110, // 1  R2 wait
        16'b001000_111_1101110, // 2  R2 clamps
        16'b000000_111_1111110, // 3  R4 reset
        16'b000000_000_1110001, // 4  R5 dormant
        16'b000000_000_1110001, // 5  R6 hold
        16'b000100_000_1111110, // 6  R6 wake
        16'b000000_000_1111110, // 7  R7 no pg
        16'b000000_110_1111110, // 8  R7 partial pg
        16'b000000_111_1111110, // 9  R7 settle
        16'b000000_111_1111110, // 10 R7
        16'b000000_111_1111110, // 11 R7
        16'b000000_111_0011110, // 12 R7 unclamp
        16'b000000_111_0001110, // 13 R7 reset release
        16'b010000_111_0001110, // 14 R8
        16'b001010_111_1101110, // 15 R8 capture dbg
        16'b000000_111_1111110, // 16 R8
        16'b000000_111_1111110, // 17 R8 emulated off
        16'b000100_111_1111110, // 18 R8
        16'b000000_111_1111110, // 19 R8
        16'b000000_111_1111110, // 20 R8
        16'b000000_111_1111110, // 21 R8
        16'b000000_111_0011110, // 22 R8
        16'b000000_111_0001110, // 23 R8
        16'b110000_111_0001110, // 24 R5 both requests
        16'b001000_111_1101110, // 25 R5
        16'b000000_111_1111110, // 26 R5
        16'b000000_000_1110000, // 27 R5 shutdown
        16'b000100_000_1111110, // 28 R6
        16'b000000_111_1111110, // 29 R7
        16'b000000_111_1111110, // 30 R7
        16'b000000_111_1111110, // 31 R7
        16'b000000_111_0011110, // 32 R7
        16'b000000_111_0001110, // 33 R7
        16'b000001_111_1001110, // 34 R9 vec clamp
        16'b000001_101_1001010, // 35 R9 vec off
        16'b100001_101_1001010, // 36 R10 request ignored
        16'b000000_101_1001110, // 37 R9 vec up
        16'b000000_101_1001110, // 38 R9 wait pg
        16'b000000_111_1001110, // 39 R9 settle
        16'b000000_111_1001110, // 40 R9
        16'b000000_111_1001110, // 41 R9
        16'b000000_111_0001110  // 42 R9 run
    };

    function automatic string tag_of(int i);
        if (i <= 2)  return "R2";
        if (i == 3)  return "R4";
        if (i == 4)  return "R5";
        if (i <= 6)  return "R6";
        if (i <= 13) return "R7";
        if (i <= 23) return "R8";
        if (i <= 27) return "R5";
        if (i == 28) return "R6";
        if (i <= 33) return "R7";
        if (i == 36) return "R10";
        return "R9";
    endfunction

    function automatic logic [6:0] outs();
        return {clamp_vec, clamp_ram, core_rst, pwr_logic_en, pwr_vec_en, pwr_ram_en, ram_retain};
    endfunction

    task automatic check(input string tag, input logic [6:0] exp);
        n_chk++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b", tag, outs(), exp);
        end
    endtask

    task automatic drive(input logic [8:0] v);
        {req_dormant, req_shutdown, core_stby_ready, wake_evt, dbg_keep_on,
         vec_off_req, pg_logic_ack, pg_vec_ack, pg_ram_ack} = v;
    endtask

    task automatic step(input logic [8:0] v);
        @(negedge clk);
        drive(v);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", 7'b0001110);            // outputs during reset
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", 7'b0001110);            // first cycle after reset

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][15:7]);
            check(tag_of(i), VEC[i][6:0]);
        end

        // R11: zero settle on the vector path
        settle_cycles = '0;
        step(9'b000001_111); check("R11", 7'b1001110);
        step(9'b000001_111); check("R11", 7'b1001010);
        step(9'b000000_111); check("R11", 7'b1001110); // VEC_UP, pg present
        step(9'b000000_111); check("R11", 7'b1001110); // one settle cycle
        step(9'b000000_111); check("R11", 7'b0001110); // back to run

        // R1: asynchronous reset in the low-power state
        step(9'b100000_111); check("R2", 7'b0001110);
        step(9'b001000_111); check("R2", 7'b1101110);
        step(9'b000000_111); check("R4", 7'b1111110);
        step(9'b000000_000); check("R5", 7'b1110001);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", 7'b0001110);
        @(negedge clk);
        rst_n = 1'b1;
        drive(9'b000000_111);
        @(posedge clk);
        #1;
        check("R1", 7'b0001110);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule